// File: doc/BRIEF.md
# Memory Sleep Entry/Exit Controller

This block sequences a synchronous memory into and out of a low-power sleep state. A request pin that has no timing relation to the clock drives it. The controller brings the request into the clock domain through a chain of flops. It then steps through a fixed entry phase, holds the sleep state for as long as the synchronized request stays high, and steps through a fixed exit phase. After that comes a recovery window, and normal accesses resume when the window closes.

While the block is in any state other than awake, the access-enable output is low and array writes are blocked, so stored contents survive the sleep period. The controller flags an access that is still outstanding when entry begins as cancelled. Two kinds of activity break the protocol: a sleep request that arrives while the memory is still selected, and any chip-enable or address-strobe activity during the recovery window. Either one sets a sticky violation flag, and the controller acts on neither.

Top module: `doze_ctrl`

## Requirements
- R1: After `doze_req_i` rises, `access_en_o` falls exactly SYNC_STAGES+1 rising clock edges later, because the request passes through a SYNC_STAGES-flop synchronizer first.
- R2: `sleep_o` rises exactly TRANS_CYCLES edges after `access_en_o` falls. `sleep_o` and `access_en_o` are never high together.
- R3: Once the synchronized request is low while asleep, `sleep_o` falls on the next edge. `access_en_o` returns high exactly TRANS_CYCLES+REC_CYCLES edges after that.
- R4: A request that is high for only one clock period still completes the full entry sequence, and sleep ends at the earliest permitted edge. A longer request holds `sleep_o` high until the synchronized request drops.
- R5: If `pend_i` is high on the edge where entry begins, `cancel_o` is high for exactly that one following cycle. At no other time is `cancel_o` high.
- R6: If any `ce_i` or `stb_i` bit is high on the edge where entry begins, `viol_o` goes high. It does not go high for such activity while the controller is asleep or in the exit phase.
- R7: Any `ce_i` or `stb_i` bit that is high on an edge inside the recovery window sets `viol_o`. That activity has no other effect: the recovery timing and `we_o` do not change.
- R8: Once `viol_o` is set it stays high until reset.
- R9: `we_o` equals `wr_i` while `access_en_o` is high and is 0 otherwise.
- R10: After asynchronous reset the outputs are `access_en_o`=1, `sleep_o`=0, `viol_o`=0 and `cancel_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| doze_req_i | input | 1 | Asynchronous sleep request, active high |
| ce_i | input | N_SEL | Chip-enable activity, active high per bit |
| stb_i | input | N_STB | Address-strobe activity, active high per bit |
| pend_i | input | 1 | An access is outstanding |
| wr_i | input | 1 | Write request toward the array |
| sleep_o | output | 1 | Sleep state active |
| access_en_o | output | 1 | Normal accesses allowed |
| we_o | output | 1 | Gated array write enable |
| cancel_o | output | 1 | One-cycle pulse: outstanding access discarded |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
The bench builds the block with SYNC_STAGES=2, TRANS_CYCLES=2, REC_CYCLES=3, N_SEL=3 and N_STB=2. The recovery window is therefore longer than the entry and exit phases, and a mix-up between the two counts shows up in the timing. The bench sweeps request lengths from one to eight cycles, which covers both the case where a short request must still finish entry and the case where sleep follows the request. For each length it places a select pulse one cycle before, at every cycle inside, and one cycle after the recovery window. It also checks the select-at-entry case and strobes during sleep and exit against arithmetic predictions.

// File: rtl/doze_pkg.sv
package doze_pkg;

   typedef enum logic [2:0] {
      ST_AWAKE   = 3'd0,
      ST_ENTER   = 3'd1,
      ST_ASLEEP  = 3'd2,
      ST_EXIT    = 3'd3,
      ST_RECOVER = 3'd4
   } doze_state_e;

   // Counter width large enough to hold the longer of two phase lengths.
   function automatic int unsigned phase_width(input int unsigned a, input int unsigned b);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m < 2) ? 1 : $clog2(m);
   endfunction

endpackage

// File: rtl/doze_sync.sv
module doze_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/doze_timer.sv
module doze_timer #(
   parameter int unsigned TW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [TW-1:0] last,
   output logic          done
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   assign done = (cnt == last);

endmodule

// File: rtl/doze_fsm.sv
module doze_fsm
   import doze_pkg::*;
#(
   parameter int unsigned TW         = 2,
   parameter int unsigned TRANS_LAST = 1,
   parameter int unsigned REC_LAST   = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_s,
   input  logic          busy,
   input  logic          pend,
   input  logic          tmr_done,
   output logic          tmr_clr,
   output logic [TW-1:0] tmr_last,
   output doze_state_e   st,
   output logic          viol,
   output logic          cancel
);

   localparam logic [TW-1:0] TRANS_L = TW'(TRANS_LAST);
   localparam logic [TW-1:0] REC_L   = TW'(REC_LAST);

   doze_state_e st_n;
   logic        begin_entry;

   always_comb begin
      st_n = st;
      unique case (st)
         ST_AWAKE:   if (req_s)    st_n = ST_ENTER;
         ST_ENTER:   if (tmr_done) st_n = ST_ASLEEP;
         ST_ASLEEP:  if (!req_s)   st_n = ST_EXIT;
         ST_EXIT:    if (tmr_done) st_n = ST_RECOVER;
         ST_RECOVER: if (tmr_done) st_n = ST_AWAKE;
         default:                  st_n = ST_AWAKE;
      endcase
   end

   assign begin_entry = (st == ST_AWAKE) && req_s;
   assign tmr_clr     = (st_n != st);
   assign tmr_last    = (st == ST_RECOVER) ? REC_L : TRANS_L;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_AWAKE;
         viol   <= 1'b0;
         cancel <= 1'b0;
      end else begin
         st     <= st_n;
         cancel <= begin_entry && pend;
         if ((begin_entry && busy) || ((st == ST_RECOVER) && busy))
            viol <= 1'b1;
      end
   end

endmodule

// File: rtl/doze_ctrl.sv
module doze_ctrl
   import doze_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned TRANS_CYCLES = 2,
   parameter int unsigned REC_CYCLES   = 2,
   parameter int unsigned N_SEL        = 3,
   parameter int unsigned N_STB        = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             doze_req_i,
   input  logic [N_SEL-1:0] ce_i,
   input  logic [N_STB-1:0] stb_i,
   input  logic             pend_i,
   input  logic             wr_i,
   output logic             sleep_o,
   output logic             access_en_o,
   output logic             we_o,
   output logic             cancel_o,
   output logic             viol_o
);

   localparam int unsigned TW = phase_width(TRANS_CYCLES, REC_CYCLES);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("doze_ctrl: SYNC_STAGES must be at least 2");
      end
      if (TRANS_CYCLES < 1 || REC_CYCLES < 1) begin : g_bad_phase
         $error("doze_ctrl: phase lengths must be at least 1");
      end
      if (N_SEL < 1 || N_STB < 1) begin : g_bad_width
         $error("doze_ctrl: select and strobe widths must be at least 1");
      end
   endgenerate

   logic          req_sync;
   logic          busy;
   logic          tmr_clr;
   logic          tmr_done;
   logic [TW-1:0] tmr_last;
   doze_state_e   st;

   assign busy = (|ce_i) | (|stb_i);

   doze_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (doze_req_i),
      .sync_out (req_sync)
   );

   doze_timer #(.TW(TW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .last  (tmr_last),
      .done  (tmr_done)
   );

   doze_fsm #(
      .TW         (TW),
      .TRANS_LAST (TRANS_CYCLES - 1),
      .REC_LAST   (REC_CYCLES - 1)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_s    (req_sync),
      .busy     (busy),
      .pend     (pend_i),
      .tmr_done (tmr_done),
      .tmr_clr  (tmr_clr),
      .tmr_last (tmr_last),
      .st       (st),
      .viol     (viol_o),
      .cancel   (cancel_o)
   );

   assign sleep_o     = (st == ST_ASLEEP);
   assign access_en_o = (st == ST_AWAKE);
   assign we_o        = wr_i & access_en_o;

endmodule

// File: rtl/doze_ctrl_chk.sv
module doze_ctrl_chk
   import doze_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        sleep_o,
   input logic        access_en_o,
   input logic        we_o,
   input logic        cancel_o,
   input logic        viol_o,
   input doze_state_e st
);

   p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_o |-> !access_en_o);

   p_entry_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_o) |-> ($past(st) == ST_ENTER));

   p_no_jump_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(access_en_o) |-> !sleep_o);

   p_wake_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(access_en_o) |-> ($past(st) == ST_RECOVER));

   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_o |=> !cancel_o);

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |=> viol_o);

   p_write_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> (access_en_o && !sleep_o));

endmodule

bind doze_ctrl doze_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_o     (sleep_o),
   .access_en_o (access_en_o),
   .we_o        (we_o),
   .cancel_o    (cancel_o),
   .viol_o      (viol_o),
   .st          (st)
);

// File: tb/doze_ctrl_test.sv
module doze_ctrl_test;

   localparam int S    = 2;
   localparam int T    = 2;
   localparam int R    = 3;
   localparam int NSEL = 3;
   localparam int NSTB = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req = 1'b0;
   logic [NSEL-1:0] ce = '0;
   logic [NSTB-1:0] stb = '0;
   logic            pend = 1'b0;
   logic            wr = 1'b0;
   logic            sleep_o, access_en_o, we_o, cancel_o, viol_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   doze_ctrl #(
      .SYNC_STAGES(S), .TRANS_CYCLES(T), .REC_CYCLES(R), .N_SEL(NSEL), .N_STB(NSTB)
   ) uut (
      .clk(clk), .rst_n(rst_n), .doze_req_i(req), .ce_i(ce), .stb_i(stb),
      .pend_i(pend), .wr_i(wr), .sleep_o(sleep_o), .access_en_o(access_en_o),
      .we_o(we_o), .cancel_o(cancel_o), .viol_o(viol_o)
   );

   task automatic chk(input string tag, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req = 1'b0; ce = '0; stb = '0; pend = 1'b0; wr = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R10 access_en after reset", access_en_o, 1'b1);
      chk("R10 sleep after reset",     sleep_o,     1'b0);
      chk("R10 viol after reset",      viol_o,      1'b0);
      chk("R10 cancel after reset",    cancel_o,    1'b0);
      chk("R9 we follows wr at reset", we_o,        1'b1);
   endtask

   // mode 0: quiet, pend high; 1: select held at entry;
   // 2: select pulse at offset p from recovery start; 3: strobes during sleep and exit
   task automatic run(input int h, input int mode, input int p);
      int x, lim;
      logic e_sleep, e_acc, e_viol, e_cancel;
      do_reset();
      x   = ((S + T + 2) > (S + h + 1)) ? (S + T + 2) : (S + h + 1);
      lim = x + T + R + 3;
      req  = 1'b1;
      pend = (mode == 0);
      if (mode == 1) ce[0] = 1'b1;
      for (int m = 1; m <= lim; m++) begin
         @(posedge clk);
         @(negedge clk);
         e_acc    = (m < S + 1) || (m >= x + T + R);
         e_sleep  = (m >= S + 1 + T) && (m < x);
         e_cancel = (mode == 0) && (m == S + 1);
         case (mode)
            1:       e_viol = (m >= S + 1);
            2:       e_viol = (p >= 0) && (p < R) && (m >= x + T + p + 1);
            default: e_viol = 1'b0;
         endcase
         chk("R1/R3 access_en timing", access_en_o, e_acc);
         chk("R2/R4 sleep timing",     sleep_o,     e_sleep);
         chk("R9 write gating",        we_o,        e_acc);
         chk("R5 cancel pulse",        cancel_o,    e_cancel);
         chk(mode == 2 ? "R7 recovery violation" :
             (mode == 1 ? "R6 select at entry" : "R6/R8 violation flag"), viol_o, e_viol);
         // drive inputs for the next edge
         if (m == h) req = 1'b0;
         ce  = '0;
         stb = '0;
         if (mode == 1 && m < S + 1) ce[0] = 1'b1;
         if (mode == 2 && m == x + T + p) ce[(p + 1) % NSEL] = 1'b1;
         if (mode == 3 && m >= S + 1 + T && m <= x + T - 1) stb[h % NSTB] = 1'b1;
      end
   endtask

   initial begin
      for (int h = 1; h <= 8; h++) begin
         run(h, 0, 0);
         run(h, 1, 0);
         for (int p = -1; p <= R; p++) run(h, 2, p);
         run(h, 3, 0);
      end
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL R1-watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule